// File: doc/BRIEF.md
# Serial configuration register slave

This block is a four-wire serial slave. A host uses it to read and write a small bank of 8-bit configuration registers. Every access is a 16-bit frame framed by an active-low select. The first byte carries a read/write flag, two reserved bits and a register address. The second byte carries write data from the host. During the same byte, the block shifts out the contents of the addressed register. The register contents are presented as parallel outputs to the logic they configure.

The pins are oversampled by a fast system clock through a synchronizer. Serial-clock edges are recovered in that clock domain. A write takes effect only when select is released after a complete, well-formed frame. A frame that is cut short, or that has nonzero reserved bits, leaves the bank and the stored address untouched. The serial output is enabled only while the host holds select low.

Top module: `ser_cfg_slave`

## Requirements
- R1: Serial input is sampled on rising serial-clock edges, most significant bit first. Frame bit 15 is the read flag (1 = read, 0 = write), bits 14:13 are reserved, bits 12:8 are the address and bits 7:0 are data. A complete write frame to address k < NREG loads bits 7:0 into register k, seen on `cfg_q[8k+7:8k]`.
- R2: No register changes while a frame is in progress, even after its 16th clock. Changes appear only after select is released.
- R3: If select is released after fewer than 16 rising serial-clock edges, no register is written and `cur_addr` keeps its value.
- R4: `cur_addr` is 0 after reset. It takes the address of every complete, valid frame, whether read or write and whether or not the address is implemented.
- R5: The byte held by the register addressed in the current frame's first byte appears on `sdo`, MSB first. It is driven after falling edges 8 to 15, so a host samples it on rising edges 9 to 16. Write frames present the contents from before the write.
- R6: The data field of a read frame changes no register.
- R7: A write to an address at or above NREG is discarded. A read of such an address returns 0x00.
- R8: A frame whose reserved bits are not both 0 writes nothing and does not update `cur_addr`.
- R9: Rising serial-clock edges beyond the 16th within one select period are ignored. The frame is formed from the first 16 bits.
- R10: `sdo_oe` is high exactly while `cs_n` is low. `sdo` is low once select has been released.
- R11: Each falling edge of select starts a new frame from its first bit, whatever an earlier, aborted frame left behind.
- R12: After reset all registers read 0x00 and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| cfg_q | output | NREG*8 | Register contents, register k in bits 8k+7:8k |
| cur_addr | output | 5 | Address captured by the last accepted frame |

## Verification
The bench builds the block with its defaults: NREG = 3 and two synchronizer stages. This leaves 29 of the 32 address codes unimplemented, so addresses 3 and 5 exercise both the discarded write and the zero read-back. The host's serial clock runs with half-periods of eight system clocks. That is well above the synchronizer latency, so every read bit is settled before the host's sampling edge. It also allows a register check between the 16th clock and the release of select. Frames of 15 and 20 clocks reach the abort and overrun corners.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int FRAME_BITS = 16;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int CW = $clog2(FRAME_BITS + 1);

  typedef struct packed {
    logic          rd;
    logic [1:0]    rsv;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } frame_t;

  function automatic frame_t split_frame(input logic [FRAME_BITS-1:0] w);
    frame_t f;
    f.rd   = w[15];
    f.rsv  = w[14:13];
    f.addr = w[12:8];
    f.data = w[7:0];
    return f;
  endfunction

  function automatic logic frame_usable(input logic [CW-1:0] n, input frame_t f);
    return (n == CW'(FRAME_BITS)) && (f.rsv == 2'b00);
  endfunction
endpackage

// File: rtl/scs_pin_sync.sv
module scs_pin_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/scs_frame.sv
module scs_frame
  import scs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          sclk_s,
  input  logic          sdi_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          commit,
  output frame_t        frame,
  output logic          sdo_bit
);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] HALF = CW'(FRAME_BITS / 2);

  logic                  sclk_d, sel_d;
  logic                  sclk_rise, sclk_fall, frame_start, frame_stop;
  logic [CW-1:0]         bit_cnt;
  logic [FRAME_BITS-1:0] shift_q;
  logic [DW-1:0]         out_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sel_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= sel;
    end
  end

  assign sclk_rise   = sclk_s & ~sclk_d;
  assign sclk_fall   = ~sclk_s & sclk_d;
  assign frame_start = sel & ~sel_d;
  assign frame_stop  = ~sel & sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shift_q <= '0;
      out_sr  <= '0;
    end else if (frame_start) begin
      bit_cnt <= '0;
      shift_q <= '0;
      out_sr  <= '0;
    end else if (frame_stop) begin
      out_sr <= '0;
    end else if (sel) begin
      if (sclk_rise && bit_cnt < FULL) begin
        shift_q <= {shift_q[FRAME_BITS-2:0], sdi_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_fall) begin
        if (bit_cnt == HALF)     out_sr <= rd_data;
        else if (bit_cnt > HALF) out_sr <= {out_sr[DW-2:0], 1'b0};
      end
    end
  end

  assign rd_addr = shift_q[AW-1:0];
  assign frame   = split_frame(shift_q);
  assign commit  = frame_stop && frame_usable(bit_cnt, frame);
  assign sdo_bit = out_sr[DW-1];

  // R9
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == FULL && !frame_start) |=> bit_cnt == FULL);

  // R10
  sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !$past(sel)) |-> !sdo_bit);
endmodule

// File: rtl/scs_reg_bank.sv
module scs_reg_bank
  import scs_pkg::*;
#(
  parameter int NREG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             wr_rd,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [NREG*DW-1:0] regs_flat,
  output logic [AW-1:0]    last_addr
);
  logic [DW-1:0] regs [NREG];
  logic [NREG-1:0] wr_vec;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wr_vec[i] = commit && !wr_rd && (wr_addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs[i] <= '0;
      else if (wr_vec[i]) regs[i] <= wr_data;
    end

    assign regs_flat[i*DW +: DW] = regs[i];

    // R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (regs[i] != $past(regs[i])) |-> $past(wr_vec[i]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == AW'(i)) rd_data = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_addr <= '0;
    else if (commit) last_addr <= wr_addr;
  end

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_addr != $past(last_addr)) |-> $past(commit));
endmodule

// File: rtl/ser_cfg_slave.sv
module ser_cfg_slave
  import scs_pkg::*;
#(
  parameter int NREG = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [NREG*8-1:0] cfg_q,
  output logic [4:0]        cur_addr
);
  logic [2:0]    pins_s;
  logic          sel;
  logic          commit;
  frame_t        frame;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  scs_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({cs_n, sclk, sdi}), .q(pins_s)
  );

  assign sel = ~pins_s[2];

  scs_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .rd_data(rd_data), .rd_addr(rd_addr), .commit(commit), .frame(frame),
    .sdo_bit(sdo)
  );

  scs_reg_bank #(.NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .wr_rd(frame.rd),
    .wr_addr(frame.addr), .wr_data(frame.data), .rd_addr(rd_addr),
    .rd_data(rd_data), .regs_flat(cfg_q), .last_addr(cur_addr)
  );

  assign sdo_oe = ~cs_n;
endmodule

// File: tb/ser_cfg_slave_tb.sv
module ser_cfg_slave_tb;
  localparam int NREG = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  wire sdo, sdo_oe;
  wire [NREG*8-1:0] cfg_q;
  wire [4:0] cur_addr;

  ser_cfg_slave #(.NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .cfg_q(cfg_q), .cur_addr(cur_addr)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] model [NREG];
  logic [4:0] model_addr = '0;
  logic [7:0] exp_q [$];
  string tag_q [$];
  int rise_n = 0;
  logic [7:0] cap = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  // driver: pushes expected read-back, runs the frame, updates the model
  task automatic frame(input logic [15:0] w, input int nclk, input string tag);
    logic [4:0] a;
    a = w[12:8];
    if (nclk >= 16) begin
      exp_q.push_back((a < NREG) ? model[a[1:0]] : 8'h00);
      tag_q.push_back({tag, " R5 read-back"});
    end
    @(negedge clk);
    cs_n = 1'b0;
    half();
    check({tag, " R10 oe while selected"}, sdo_oe, 1);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? w[15 - i] : 1'b1;
      half();
      sclk = 1'b1;
      half();
      sclk = 1'b0;
    end
    half();
    check({tag, " R2 no change before release"}, cfg_q, model_flat());
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
    if (nclk >= 16 && w[14:13] == 2'b00) begin
      model_addr = a;
      if (!w[15] && a < NREG) model[a[1:0]] = w[7:0];
    end
    check({tag, " R1 registers"}, cfg_q, model_flat());
    check({tag, " R4 cur_addr"}, cur_addr, model_addr);
    check({tag, " R10 idle"}, {sdo_oe, sdo}, 0);
  endtask

  // monitor: captures sdo on host sampling edges 9..16, compares with queue
  always @(negedge cs_n) begin
    rise_n = 0;
    cap = '0;
  end
  always @(posedge sclk) if (!cs_n) begin
    rise_n++;
    if (rise_n >= 9 && rise_n <= 16) cap = {cap[6:0], sdo};
  end
  always @(posedge cs_n) if (rise_n >= 16 && exp_q.size() > 0) begin
    check(tag_q.pop_front(), cap, exp_q.pop_front());
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R12 reset state
    check("R12 registers", cfg_q, 0);
    check("R12 oe", sdo_oe, 0);
    check("R4 reset address", cur_addr, 0);

    frame(16'h01A5, 16, "R1 write 1");
    frame(16'h003C, 16, "R1 write 0");
    frame(16'h02F0, 16, "R1 write 2");
    frame(16'h81FF, 16, "R6 read 1");
    frame(16'h8000, 16, "R5 read 0");
    frame(16'h8255, 16, "R5 read 2");
    frame(16'h0211, 15, "R3 short");
    frame(16'h0266, 16, "R11 after abort");
    frame(16'h8200, 16, "R11 read back");
    frame(16'h0577, 16, "R7 write high");
    frame(16'h8500, 16, "R7 read high");
    frame(16'h8300, 16, "R7 read 3");
    frame(16'h2199, 16, "R8 rsv13");
    frame(16'h4099, 16, "R8 rsv14");
    frame(16'h000C, 20, "R9 long write");
    frame(16'h8000, 20, "R9 long read");
    frame(16'h01C3, 16, "R1 rewrite 1");
    frame(16'h8100, 16, "R5 read new 1");
    check("R5 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule